// File: doc/BRIEF.md
# Iterative MD5 Block Compression Engine

This block runs the MD5 compression function over one 512-bit message block. It has one step datapath, and that datapath is reused once per clock for all 64 steps. Software or an upstream controller first writes the sixteen 32-bit message words into an internal store through a simple write port. It then issues one of two commands. One command starts a fresh digest from the standard initial chaining value. The other continues a multi-block message from the digest left by the previous block. Padding and length appending are done outside the block.

A six-bit step counter selects three things at once: the message word each step reads, the additive constant, and the rotate amount. When the last step completes, one more cycle adds the chaining value saved at the start back into the working registers. That sum is published on `digest` and `done` is raised. The result then stays on the port until the next command is accepted.

Top module: `md5_iter_core`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `digest` is all zeros.
- R2: `begin_first` seeds the working registers with A=67452301h, B=efcdab89h, C=98badcfeh and D=10325476h. The final digest equals the MD5 compression of the stored block from that seed. The digest is packed with A in bits 31:0, B in 63:32, C in 95:64 and D in 127:96. Message word w (written at `msg_addr`=w) is MD5 word X[w]. For example, the padded empty message gives 7e42f8ec_980980e9_04b2008f_d98c1dd4h.
- R3: `begin_next` seeds the working registers with the current `digest` value instead of the constants. The result is the compression of the stored block from that value.
- R4: The clock edge that accepts a command is counted as edge 1. `done` goes high after edge 66 and is low from edge 1 until then.
- R5: When idle, a `msg_we` pulse writes `msg_word` into word `msg_addr`. While a block is in progress (edges 2 to 66 after acceptance), `msg_we` is ignored and the store is unchanged.
- R6: `begin_first` or `begin_next` arriving while a block is in progress is ignored. The running block finishes with its original timing and result.
- R7: Once `done` is high, it stays high with `digest` unchanged until a command is accepted. It falls at the edge that accepts the command.
- R8: If `begin_first` and `begin_next` are both high together, `begin_first` takes priority.
- R9: `digest` does not change while a block is in progress, except at the final edge that publishes the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_word | input | 32 | Message word to store |
| msg_addr | input | 4 | Word index within the 512-bit block |
| msg_we | input | 1 | Store write strobe, honoured only when idle |
| begin_first | input | 1 | Start a block from the standard initial value |
| begin_next | input | 1 | Start a block from the current digest |
| digest | output | 128 | Chaining value / result, A in the low lane |
| done | output | 1 | Result valid, held until the next accepted command |

## Verification
The checker takes two things for granted. Inputs are synchronous levels that are sampled only at rising edges, and reset is released away from an edge. Its latency and stability properties count cycles from the edge where a command is seen while the core is idle. The bench drives every input on the falling edge and holds each command or write for exactly one cycle. It also deliberately issues writes, second commands and both commands at once while a block runs. This way the ignore and priority rules are exercised inside those assumptions.

// File: rtl/md5_pkg.sv
package md5_pkg;

  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // Chaining value; lane A sits in the least significant bits.
  typedef struct packed {
    word_t d;
    word_t c;
    word_t b;
    word_t a;
  } chain_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FOLD = 2'd2
  } phase_e;

  localparam chain_t MD5_SEED = '{
    d: 32'h10325476,
    c: 32'h98badcfe,
    b: 32'hefcdab89,
    a: 32'h67452301
  };

  function automatic word_t md5_const(input logic [5:0] i);
    case (i)
      6'd0:  return 32'hd76aa478;  6'd1:  return 32'he8c7b756;
      6'd2:  return 32'h242070db;  6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf;  6'd5:  return 32'h4787c62a;
      6'd6:  return 32'ha8304613;  6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8;  6'd9:  return 32'h8b44f7af;
      6'd10: return 32'hffff5bb1;  6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122;  6'd13: return 32'hfd987193;
      6'd14: return 32'ha679438e;  6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562;  6'd17: return 32'hc040b340;
      6'd18: return 32'h265e5a51;  6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d;  6'd21: return 32'h02441453;
      6'd22: return 32'hd8a1e681;  6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6;  6'd25: return 32'hc33707d6;
      6'd26: return 32'hf4d50d87;  6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905;  6'd29: return 32'hfcefa3f8;
      6'd30: return 32'h676f02d9;  6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942;  6'd33: return 32'h8771f681;
      6'd34: return 32'h6d9d6122;  6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44;  6'd37: return 32'h4bdecfa9;
      6'd38: return 32'hf6bb4b60;  6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6;  6'd41: return 32'heaa127fa;
      6'd42: return 32'hd4ef3085;  6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039;  6'd45: return 32'he6db99e5;
      6'd46: return 32'h1fa27cf8;  6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244;  6'd49: return 32'h432aff97;
      6'd50: return 32'hab9423a7;  6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3;  6'd53: return 32'h8f0ccc92;
      6'd54: return 32'hffeff47d;  6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f;  6'd57: return 32'hfe2ce6e0;
      6'd58: return 32'ha3014314;  6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82;  6'd61: return 32'hbd3af235;
      6'd62: return 32'h2ad7d2bb;  6'd63: return 32'heb86d391;
    endcase
  endfunction

  // Rotate amount depends only on the round and the step's position mod 4.
  function automatic logic [4:0] md5_rot(input logic [5:0] i);
    case ({i[5:4], i[1:0]})
      4'h0: return 5'd7;   4'h1: return 5'd12;  4'h2: return 5'd17;  4'h3: return 5'd22;
      4'h4: return 5'd5;   4'h5: return 5'd9;   4'h6: return 5'd14;  4'h7: return 5'd20;
      4'h8: return 5'd4;   4'h9: return 5'd11;  4'ha: return 5'd16;  4'hb: return 5'd23;
      4'hc: return 5'd6;   4'hd: return 5'd10;  4'he: return 5'd15;  4'hf: return 5'd21;
    endcase
  endfunction

  // Message word read by step i, all arithmetic mod 16.
  function automatic logic [3:0] md5_widx(input logic [5:0] i);
    case (i[5:4])
      2'd0: return i[3:0];
      2'd1: return 4'(i[3:0] * 4'd5 + 4'd1);
      2'd2: return 4'(i[3:0] * 4'd3 + 4'd5);
      2'd3: return 4'(i[3:0] * 4'd7);
    endcase
  endfunction

  function automatic word_t md5_mix(input logic [1:0] rnd, input word_t x,
                                    input word_t y, input word_t z);
    case (rnd)
      2'd0: return (x & y) | (~x & z);
      2'd1: return (x & z) | (y & ~z);
      2'd2: return x ^ y ^ z;
      2'd3: return y ^ (x | ~z);
    endcase
  endfunction

endpackage

// File: rtl/md5_msg_store.sv
module md5_msg_store #(
  parameter int WORDS = 16,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [W-1:0]             rd_data
);

  localparam int AW = $clog2(WORDS);

  logic [WORDS*W-1:0] flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic         hit;
    logic [W-1:0] word_q;

    assign hit = wr_en && (wr_addr == AW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        word_q <= wr_data;
      end
    end

    assign flat[w*W +: W] = word_q;
  end

  assign rd_data = flat[rd_addr*W +: W];

endmodule

// File: rtl/md5_step_sched.sv
module md5_step_sched
  import md5_pkg::*;
(
  input  logic [5:0] step,
  output logic [3:0] widx,
  output word_t      konst,
  output logic [4:0] rot,
  output logic [1:0] rnd
);

  always_comb begin
    widx  = md5_widx(step);
    konst = md5_const(step);
    rot   = md5_rot(step);
    rnd   = step[5:4];
  end

endmodule

// File: rtl/md5_round_fn.sv
module md5_round_fn
  import md5_pkg::*;
(
  input  chain_t     cur,
  input  word_t      msg,
  input  word_t      konst,
  input  logic [4:0] rot,
  input  logic [1:0] rnd,
  output chain_t     nxt
);

  word_t                 mixed;
  word_t                 total;
  logic [2*WORD_W-1:0]   spun;

  always_comb begin
    mixed = md5_mix(rnd, cur.b, cur.c, cur.d);
    total = cur.a + mixed + msg + konst;
    spun  = {total, total} << rot;
    nxt.a = cur.d;
    nxt.d = cur.c;
    nxt.c = cur.b;
    nxt.b = cur.b + spun[2*WORD_W-1:WORD_W];
  end

endmodule

// File: rtl/md5_iter_core.sv
module md5_iter_core
  import md5_pkg::*;
#(
  parameter int MSG_WORDS = 16,
  parameter int STEPS     = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WORD_W-1:0]             msg_word,
  input  logic [$clog2(MSG_WORDS)-1:0]  msg_addr,
  input  logic                          msg_we,
  input  logic                          begin_first,
  input  logic                          begin_next,
  output logic [4*WORD_W-1:0]           digest,
  output logic                          done
);

  localparam int AW    = $clog2(MSG_WORDS);
  localparam int CW    = $clog2(STEPS);
  localparam int LANES = 4;

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  chain_t          work_q, work_d;
  chain_t          save_q;
  logic [4*WORD_W-1:0] dig_q, fold_sum;
  logic            done_q, done_d;

  logic            accept, running, folding, last_step, busy;
  logic            work_en, cnt_en, save_en, dig_en, done_en;
  chain_t          seed, step_out;

  logic [AW-1:0]   widx;
  word_t           konst, msg_rd;
  logic [4:0]      rot;
  logic [1:0]      rnd;

  md5_msg_store #(.WORDS(MSG_WORDS), .W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (msg_we && !busy),
    .wr_addr (msg_addr),
    .wr_data (msg_word),
    .rd_addr (widx),
    .rd_data (msg_rd)
  );

  md5_step_sched u_sched (
    .step  (cnt_q),
    .widx  (widx),
    .konst (konst),
    .rot   (rot),
    .rnd   (rnd)
  );

  md5_round_fn u_round (
    .cur   (work_q),
    .msg   (msg_rd),
    .konst (konst),
    .rot   (rot),
    .rnd   (rnd),
    .nxt   (step_out)
  );

  // Final feed-forward: one adder per lane.
  for (genvar l = 0; l < LANES; l++) begin : g_fold
    assign fold_sum[l*WORD_W +: WORD_W] =
      work_q[l*WORD_W +: WORD_W] + save_q[l*WORD_W +: WORD_W];
  end

  // Next-state logic
  always_comb begin
    running   = (phase_q == PH_RUN);
    folding   = (phase_q == PH_FOLD);
    busy      = (phase_q != PH_IDLE);
    accept    = (begin_first || begin_next) && !busy;
    last_step = running && (cnt_q == CW'(STEPS-1));
    seed      = begin_first ? MD5_SEED : chain_t'(dig_q);

    work_en = accept || running;
    work_d  = accept ? seed : step_out;
    save_en = accept;
    cnt_en  = accept || running;
    cnt_d   = accept ? '0 : cnt_q + 1'b1;
    dig_en  = folding;
    done_en = accept || folding;
    done_d  = folding;

    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (accept)    phase_d = PH_RUN;
      PH_RUN:  if (last_step) phase_d = PH_FOLD;
      PH_FOLD:                phase_d = PH_IDLE;
      default:                phase_d = PH_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      work_q  <= '0;
      save_q  <= '0;
      dig_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (work_en) work_q <= work_d;
      if (save_en) save_q <= seed;
      if (dig_en)  dig_q  <= fold_sum;
      if (done_en) done_q <= done_d;
    end
  end

  assign digest = dig_q;
  assign done   = done_q;

endmodule

// File: rtl/md5_iter_core_chk.sv
module md5_iter_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         begin_first,
  input logic         begin_next,
  input logic         busy,
  input logic         done,
  input logic [127:0] digest
);

  // Edges since the accepting edge (which counts as 1), saturating.
  logic [6:0] lat;
  logic       cmd;

  assign cmd = begin_first || begin_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
    end else if (cmd && !busy) begin
      lat <= 7'd1;
    end else if (lat != 7'd0 && lat != 7'h7f) begin
      lat <= lat + 7'd1;
    end
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lat == 7'd66);

  a_r4_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  a_r6_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat != 7'd65) |=> busy);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd) |=> (done && $stable(digest)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd) |=> !done);

  a_r9_digest_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat != 7'd65) |=> $stable(digest));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!done && digest == '0));

endmodule

bind md5_iter_core md5_iter_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .begin_first (begin_first),
  .begin_next  (begin_next),
  .busy        (busy),
  .done        (done),
  .digest      (digest)
);

// File: tb/md5_iter_core_bench.sv
module md5_iter_core_bench;

  localparam logic [127:0] SEED  = 128'h10325476_98badcfe_efcdab89_67452301;
  localparam logic [127:0] EMPTY = 128'h7e42f8ec_980980e9_04b2008f_d98c1dd4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  msg_word = '0;
  logic [3:0]   msg_addr = '0;
  logic         msg_we = 1'b0;
  logic         begin_first = 1'b0;
  logic         begin_next = 1'b0;
  logic [127:0] digest;
  logic         done;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  md5_iter_core u_md5_iter_core (
    .clk(clk), .rst_n(rst_n), .msg_word(msg_word), .msg_addr(msg_addr),
    .msg_we(msg_we), .begin_first(begin_first), .begin_next(begin_next),
    .digest(digest), .done(done)
  );

  // Behavioural reference
  logic [31:0] tk [64];
  int sh [16] = '{7, 12, 17, 22, 5, 9, 14, 20, 4, 11, 16, 23, 6, 10, 15, 21};

  initial begin
    for (int i = 0; i < 64; i++) begin
      real r;
      r = $sin(real'(i + 1));
      if (r < 0.0) r = -r;
      tk[i] = 32'(longint'($floor(r * 4294967296.0)));
    end
  end

  function automatic logic [127:0] ref_compress(input logic [127:0] ch, input logic [511:0] blk);
    logic [31:0] a, b, c, d, f, t, sum;
    int g, s;
    a = ch[31:0]; b = ch[63:32]; c = ch[95:64]; d = ch[127:96];
    for (int i = 0; i < 64; i++) begin
      case (i / 16)
        0: begin f = (b & c) | (~b & d); g = i; end
        1: begin f = (b & d) | (c & ~d); g = (5 * i + 1) % 16; end
        2: begin f = b ^ c ^ d;          g = (3 * i + 5) % 16; end
        default: begin f = c ^ (b | ~d); g = (7 * i) % 16; end
      endcase
      s = sh[(i / 16) * 4 + i % 4];
      sum = a + f + tk[i] + blk[g*32 +: 32];
      t = d; d = c; c = b;
      b = b + ((sum << s) | (sum >> (32 - s)));
      a = t;
    end
    return {d + ch[127:96], c + ch[95:64], b + ch[63:32], a + ch[31:0]};
  endfunction

  logic [511:0] rblk;
  logic [127:0] rdig, rstart, rpend;
  logic         rdone;
  int           cd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rblk = '0; rdig = '0; rdone = 1'b0; cd = 0; rstart = '0; rpend = '0;
    end else if (cd != 0) begin
      cd = cd - 1;
      if (cd == 64) rpend = ref_compress(rstart, rblk);
      if (cd == 0) begin rdone = 1'b1; rdig = rpend; end
    end else begin
      if (msg_we) rblk[msg_addr*32 +: 32] = msg_word;
      if (begin_first || begin_next) begin
        rstart = begin_first ? SEED : rdig;
        cd = 65;
        rdone = 1'b0;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === rdone, "R4", 128'(done), 128'(rdone));
      chk(digest === rdig, (cd != 0) ? "R9" : cur_req, digest, rdig);
    end
  end

  task automatic put_block(input logic [511:0] blk);
    for (int w = 0; w < 16; w++) begin
      @(negedge clk);
      msg_we = 1'b1; msg_addr = 4'(w); msg_word = blk[w*32 +: 32];
    end
    @(negedge clk);
    msg_we = 1'b0;
  endtask

  task automatic run_block(input logic f, input logic n, output int cycles);
    @(negedge clk);
    begin_first = f; begin_next = n;
    @(negedge clk);
    begin_first = 1'b0; begin_next = 1'b0;
    cycles = 1;
    chk(!done, "R7", 128'(done), 128'(0));
    while (!done && cycles < 200) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [511:0] blk2, blk3;
    logic [127:0] prev, expv;

    repeat (3) @(negedge clk);
    chk(!done && digest == '0, "R1", digest, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && digest == '0, "R1", digest, '0);

    // Padded empty message, fresh start
    cur_req = "R5";
    put_block({480'b0, 32'h00000080});
    cur_req = "R2";
    run_block(1'b1, 1'b0, n);
    chk(n == 66, "R4", 128'(n), 128'(66));
    chk(digest === EMPTY, "R2", digest, EMPTY);

    // Result held while idle
    cur_req = "R7";
    repeat (6) @(negedge clk);
    chk(done && digest === EMPTY, "R7", digest, EMPTY);

    // Continuation from current digest
    cur_req = "R3";
    for (int w = 0; w < 16; w++) blk2[w*32 +: 32] = 32'h01234567 * (w + 3) ^ 32'(w << 24);
    put_block(blk2);
    prev = digest;
    run_block(1'b0, 1'b1, n);
    expv = ref_compress(prev, blk2);
    chk(digest === expv, "R3", digest, expv);

    // Writes and commands during a block are ignored
    cur_req = "R6";
    prev = digest;
    @(negedge clk);
    begin_next = 1'b1;
    @(negedge clk);
    begin_next = 1'b0;
    n = 1;
    while (!done && n < 200) begin
      if (n == 10) begin msg_we = 1'b1; msg_addr = 4'd5; msg_word = 32'hdeadbeef; end
      else if (n == 11) msg_we = 1'b0;
      if (n == 20) begin_first = 1'b1;
      else if (n == 21) begin_first = 1'b0;
      if (n == 40) begin_next = 1'b1;
      else if (n == 41) begin_next = 1'b0;
      @(negedge clk);
      n++;
    end
    expv = ref_compress(prev, blk2);
    chk(n == 66, "R6", 128'(n), 128'(66));
    chk(digest === expv, "R6", digest, expv);

    cur_req = "R5";
    run_block(1'b1, 1'b0, n);
    expv = ref_compress(SEED, blk2);
    chk(digest === expv, "R5", digest, expv);

    // Both commands together: fresh start wins
    cur_req = "R8";
    repeat (2) @(negedge clk);
    run_block(1'b1, 1'b1, n);
    chk(digest === expv, "R8", digest, expv);

    // Random multi-block chains
    for (int k = 0; k < 4; k++) begin
      cur_req = "R2";
      for (int w = 0; w < 16; w++) blk3[w*32 +: 32] = $urandom;
      put_block(blk3);
      prev = (k % 2 == 0) ? SEED : digest;
      run_block(k % 2 == 0, k % 2 != 0, n);
      expv = ref_compress(prev, blk3);
      chk(digest === expv, (k % 2 == 0) ? "R2" : "R3", digest, expv);
      chk(n == 66, "R4", 128'(n), 128'(66));
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule